// File: doc/BRIEF.md
# Multi-Port Receive Frame Dispatcher

The dispatcher hands received Ethernet frames from eight per-port receive queues to a single host read bus. At any moment one port is selected. The host sees that port's number and a flag that tells it whether the port holds at least one complete frame. The host can start the transfer of that frame with a pass request, or move the selection on to the next port with a skip request. A passed frame streams out one word per enabled cycle. Each word carries a 4-bit attribute code that marks the first word, the middle words and the final word. The final word also states how many of its bytes are valid.

An optional tail mode adds two words after the frame data: a length word with the frame's byte count, and a status word. The bus width is a parameter and can be 32 or 64 bits. The host gates the whole read side with an active-low enable. Every output is registered from the enable sampled at the previous edge, so `busDriven` marks the cycles in which the outputs are meaningful. In this model the queues are plain word buffers, filled through a load port.

Top module: `rx_frame_dispatch`

## Requirements
- R1: After reset `busDriven`, `rdValid` and `frameAvail` are 0, `rdPort` is 0, and the first enabled cycle selects port 0.
- R2: In a cycle that follows an edge at which `rdEnN` was high, `busDriven` is 0 and `rdPort`, `frameAvail`, `rdValid`, `rdData` and `rdAttr` are all zero. Pass and skip requests sampled while `rdEnN` is high have no effect.
- R3: `frameAvail` is 1 only when the selected port holds at least one frame whose final word (`loadLast`) has been loaded. A frame that is only partly loaded does not set it.
- R4: An idle skip request moves the selection to the next higher port and wraps from 7 to 0. When skip and pass are both requested, skip wins and no transfer starts.
- R5: A pass request on a port with `frameAvail` high starts a transfer. The first word appears two edges after the pass edge, and the frame's words follow in load order. A pass request on a port that holds no complete frame is ignored.
- R6: The attribute codes are 4'b0001 for the first word and 4'b0000 for a middle word. A final word has bit 3 set and bits 2:0 equal to its valid-byte count modulo 8, so a full 64-bit word gives 4'b1000. A frame of one word carries only the final-word code.
- R7: With `tailMode` set, the final word is followed by a length word (attribute 4'b0010, data = total valid bytes) and then a status word (attribute 4'b0011, data bits 18:16 = port number, bits 15:0 = count of data words).
- R8: A passed frame stays in its queue until its final word has been emitted, or its status word in tail mode. Until then `frameAvail` for that port stays 1.
- R9: While `rdEnN` is high during a transfer, no word is emitted and none is lost. The transfer resumes with the next word once the enable returns.
- R10: Skip and pass requests made during a transfer are ignored, and the selected port does not change until the transfer ends.
- R11: At 64-bit width a final word can carry 1 to 8 valid bytes. Seven bytes give code 4'b1111, and the length word counts 8 bytes for each full word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host-side clock |
| rstN | input | 1 | Active-low reset |
| loadValid | input | 1 | Writes one word into a port queue |
| loadPort | input | 3 | Queue that receives the loaded word |
| loadData | input | DATA_W | Loaded data word |
| loadLast | input | 1 | Loaded word ends a frame |
| loadBytes | input | $clog2(DATA_W/8+1) | Valid bytes in a final word (1 to DATA_W/8) |
| rdEnN | input | 1 | Active-low read enable |
| passReq | input | 1 | Start transfer from the selected port |
| skipReq | input | 1 | Advance to the next port |
| tailMode | input | 1 | Append length and status words |
| busDriven | output | 1 | Read outputs are meaningful this cycle |
| rdPort | output | 3 | Selected port number |
| frameAvail | output | 1 | Selected port holds a complete frame |
| rdValid | output | 1 | A word is presented on rdData |
| rdData | output | DATA_W | Frame, length or status word |
| rdAttr | output | 4 | Word attribute code |

## Verification
The properties assume that the host never loads into a queue beyond its depth, and that every loaded frame ends with a word that has `loadLast` set and a byte count between 1 and the bus width in bytes. The stimulus keeps every queue far below its depth and gives every final word a legal byte count. The bench does leave one frame partly loaded on purpose to exercise R3. The assertions also take `tailMode` as stable while a transfer is in flight, and the bench changes it only while the dispatcher is idle.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_LEN,
    ST_STAT
  } rfdState_e;

  typedef struct packed {
    logic startXfer;
    logic readWord;
    logic emitLen;
    logic emitStat;
    logic commit;
  } rfdStrobe_t;

  localparam logic [3:0] ATTR_MID   = 4'b0000;
  localparam logic [3:0] ATTR_START = 4'b0001;
  localparam logic [3:0] ATTR_LEN   = 4'b0010;
  localparam logic [3:0] ATTR_STAT  = 4'b0011;

endpackage

// File: rtl/rfd_port_queue.sv
module rfd_port_queue #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [CNT_W-1:0]  wrBytes,
  input  logic [AW-1:0]     rdAddr,
  input  logic              commit,
  input  logic [AW-1:0]     commitHead,
  output logic [AW-1:0]     headPtr,
  output logic              hasFrame,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic [CNT_W-1:0]  rdBytes
);

  logic [DATA_W-1:0] dataMem  [DEPTH];
  logic              lastMem  [DEPTH];
  logic [CNT_W-1:0]  bytesMem [DEPTH];
  logic [AW-1:0]     tailPtr;
  logic [FW-1:0]     frameCnt;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      dataMem[tailPtr]  <= wrData;
      lastMem[tailPtr]  <= wrLast;
      bytesMem[tailPtr] <= wrBytes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailPtr  <= '0;
      headPtr  <= '0;
      frameCnt <= '0;
    end else begin
      if (wrEn) tailPtr <= tailPtr + 1'b1;
      if (commit) headPtr <= commitHead;
      case ({wrEn && wrLast, commit})
        2'b10:   frameCnt <= frameCnt + 1'b1;
        2'b01:   frameCnt <= frameCnt - 1'b1;
        default: frameCnt <= frameCnt;
      endcase
    end
  end

  assign hasFrame = (frameCnt != '0);
  assign rdData   = dataMem[rdAddr];
  assign rdLast   = lastMem[rdAddr];
  assign rdBytes  = bytesMem[rdAddr];

endmodule

// File: rtl/rfd_datapath.sv
module rfd_datapath
  import rfd_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int BYTES    = DATA_W / 8,
  localparam int CNT_W    = $clog2(BYTES + 1),
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [PORT_W-1:0] loadPort,
  input  logic [DATA_W-1:0] loadData,
  input  logic              loadLast,
  input  logic [CNT_W-1:0]  loadBytes,
  input  logic [PORT_W-1:0] curPort,
  input  rfdStrobe_t        strb,
  output logic [NUM_PORTS-1:0] availVec,
  output logic              lastWord,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        rdAttr
);

  logic [DATA_W-1:0] qData  [NUM_PORTS];
  logic              qLast  [NUM_PORTS];
  logic [CNT_W-1:0]  qBytes [NUM_PORTS];
  logic [AW-1:0]     qHead  [NUM_PORTS];

  logic [AW-1:0] rdPtr;
  logic [AW-1:0] commitHead;
  logic [15:0]   byteAcc;
  logic [15:0]   wordCnt;

  assign commitHead = strb.readWord ? rdPtr + 1'b1 : rdPtr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_queue
    rfd_port_queue #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .DEPTH (DEPTH)
    ) queue_i (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (loadValid && (loadPort == PORT_W'(p))),
      .wrData    (loadData),
      .wrLast    (loadLast),
      .wrBytes   (loadBytes),
      .rdAddr    (rdPtr),
      .commit    (strb.commit && (curPort == PORT_W'(p))),
      .commitHead(commitHead),
      .headPtr   (qHead[p]),
      .hasFrame  (availVec[p]),
      .rdData    (qData[p]),
      .rdLast    (qLast[p]),
      .rdBytes   (qBytes[p])
    );
  end

  logic [DATA_W-1:0] selData;
  logic [CNT_W-1:0]  selBytes;

  assign selData  = qData[curPort];
  assign selBytes = qBytes[curPort];
  assign lastWord = qLast[curPort];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      byteAcc <= '0;
      wordCnt <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      rdAttr  <= '0;
    end else begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdAttr  <= '0;
      if (strb.startXfer) begin
        rdPtr   <= qHead[curPort];
        byteAcc <= '0;
        wordCnt <= '0;
      end
      if (strb.readWord) begin
        rdValid <= 1'b1;
        rdData  <= selData;
        rdPtr   <= rdPtr + 1'b1;
        wordCnt <= wordCnt + 1'b1;
        if (lastWord) begin
          rdAttr  <= {1'b1, 3'(selBytes)};
          byteAcc <= byteAcc + 16'(selBytes);
        end else begin
          rdAttr  <= (wordCnt == '0) ? ATTR_START : ATTR_MID;
          byteAcc <= byteAcc + 16'(BYTES);
        end
      end
      if (strb.emitLen) begin
        rdValid <= 1'b1;
        rdData  <= DATA_W'(byteAcc);
        rdAttr  <= ATTR_LEN;
      end
      if (strb.emitStat) begin
        rdValid <= 1'b1;
        rdData  <= DATA_W'({curPort, wordCnt});
        rdAttr  <= ATTR_STAT;
      end
    end
  end

endmodule

// File: rtl/rfd_ctrl.sv
module rfd_ctrl
  import rfd_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEnN,
  input  logic                 passReq,
  input  logic                 skipReq,
  input  logic                 tailMode,
  input  logic [NUM_PORTS-1:0] availVec,
  input  logic                 lastWord,
  output logic [PORT_W-1:0]    curPort,
  output rfdStrobe_t           strb,
  output logic                 xferBusy,
  output logic                 drvQ
);

  rfdState_e         state, stateNext;
  logic [PORT_W-1:0] portNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    portNext  = curPort;
    if (!rdEnN) begin
      unique case (state)
        ST_IDLE: begin
          if (skipReq) begin
            portNext = (curPort == PORT_W'(NUM_PORTS - 1)) ? '0 : curPort + 1'b1;
          end else if (passReq && availVec[curPort]) begin
            strb.startXfer = 1'b1;
            stateNext      = ST_XFER;
          end
        end
        ST_XFER: begin
          strb.readWord = 1'b1;
          if (lastWord) begin
            if (tailMode) begin
              stateNext = ST_LEN;
            end else begin
              strb.commit = 1'b1;
              stateNext   = ST_IDLE;
            end
          end
        end
        ST_LEN: begin
          strb.emitLen = 1'b1;
          stateNext    = ST_STAT;
        end
        ST_STAT: begin
          strb.emitStat = 1'b1;
          strb.commit   = 1'b1;
          stateNext     = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curPort <= '0;
      drvQ    <= 1'b0;
    end else begin
      state   <= stateNext;
      curPort <= portNext;
      drvQ    <= !rdEnN;
    end
  end

  assign xferBusy = (state != ST_IDLE);

endmodule

// File: rtl/rx_frame_dispatch.sv
module rx_frame_dispatch
  import rfd_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int CNT_W    = $clog2(DATA_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [PORT_W-1:0] loadPort,
  input  logic [DATA_W-1:0] loadData,
  input  logic              loadLast,
  input  logic [CNT_W-1:0]  loadBytes,
  input  logic              rdEnN,
  input  logic              passReq,
  input  logic              skipReq,
  input  logic              tailMode,
  output logic              busDriven,
  output logic [PORT_W-1:0] rdPort,
  output logic              frameAvail,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        rdAttr
);

  rfdStrobe_t           strb;
  logic [NUM_PORTS-1:0] availVec;
  logic [PORT_W-1:0]    curPort;
  logic                 lastWord;
  logic                 xferBusy;
  logic                 availCur;

  rfd_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdEnN   (rdEnN),
    .passReq (passReq),
    .skipReq (skipReq),
    .tailMode(tailMode),
    .availVec(availVec),
    .lastWord(lastWord),
    .curPort (curPort),
    .strb    (strb),
    .xferBusy(xferBusy),
    .drvQ    (busDriven)
  );

  rfd_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .loadPort (loadPort),
    .loadData (loadData),
    .loadLast (loadLast),
    .loadBytes(loadBytes),
    .curPort  (curPort),
    .strb     (strb),
    .availVec (availVec),
    .lastWord (lastWord),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdAttr   (rdAttr)
  );

  assign availCur   = availVec[curPort];
  assign frameAvail = busDriven && availCur;
  assign rdPort     = busDriven ? curPort : '0;

endmodule

// File: rtl/rx_frame_dispatch_chk.sv
module rx_frame_dispatch_chk #(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEnN,
  input logic              passReq,
  input logic              skipReq,
  input logic              busDriven,
  input logic              rdValid,
  input logic [3:0]        rdAttr,
  input logic [PORT_W-1:0] rdPort,
  input logic              frameAvail,
  input logic [PORT_W-1:0] curPort,
  input logic              xferBusy,
  input logic              availCur
);

  // R2: nothing shown while the bus is released
  a_r2_quiet_when_released: assert property (@(posedge clk) disable iff (!rstN)
    !busDriven |-> (!rdValid && !frameAvail && rdPort == '0 && rdAttr == 4'b0000));

  // R9: a word only appears on an enabled cycle
  a_r9_word_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busDriven);

  // R6: only legal attribute codes on emitted words
  a_r6_attr_legal: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdAttr[3] || rdAttr[2:0] <= 3'd3));

  // R4: idle skip steps the selection by one with wrap
  a_r4_skip_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEnN && skipReq && !xferBusy) |=> curPort == PORT_W'($past(curPort) + 1'b1));

  // R10: selection frozen during a transfer
  a_r10_port_frozen: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |=> curPort == $past(curPort));

  // R5: pass without a complete frame does not start a transfer
  a_r5_no_frame_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEnN && passReq && !skipReq && !xferBusy && !availCur) |=> !xferBusy);

  // R2: requests with the read side disabled change nothing
  a_r2_disabled_no_move: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnN && !xferBusy) |=> (!xferBusy && curPort == $past(curPort)));

endmodule

bind rx_frame_dispatch rx_frame_dispatch_chk #(.PORT_W(PORT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdEnN     (rdEnN),
  .passReq   (passReq),
  .skipReq   (skipReq),
  .busDriven (busDriven),
  .rdValid   (rdValid),
  .rdAttr    (rdAttr),
  .rdPort    (rdPort),
  .frameAvail(frameAvail),
  .curPort   (curPort),
  .xferBusy  (xferBusy),
  .availCur  (availCur)
);

// File: tb/rx_frame_dispatch_tb_top.sv
module rx_frame_dispatch_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // 32-bit instance
  logic        loadValid = 0, loadLast = 0, rdEnN = 1, passReq = 0, skipReq = 0, tailMode = 0;
  logic [2:0]  loadPort = 0, loadBytes = 0;
  logic [31:0] loadData = 0;
  logic        busDriven, frameAvail, rdValid;
  logic [2:0]  rdPort;
  logic [31:0] rdData;
  logic [3:0]  rdAttr;

  // 64-bit instance
  logic        wLoadValid = 0, wLoadLast = 0, wRdEnN = 1, wPass = 0, wTail = 0;
  logic [2:0]  wLoadPort = 0;
  logic [3:0]  wLoadBytes = 0;
  logic [63:0] wLoadData = 0;
  logic        wBusDriven, wFrameAvail, wRdValid;
  logic [2:0]  wRdPort;
  logic [63:0] wRdData;
  logic [3:0]  wRdAttr;

  int tests = 0;
  int fails = 0;

  rx_frame_dispatch #(.DATA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadPort(loadPort),
    .loadData(loadData), .loadLast(loadLast), .loadBytes(loadBytes),
    .rdEnN(rdEnN), .passReq(passReq), .skipReq(skipReq), .tailMode(tailMode),
    .busDriven(busDriven), .rdPort(rdPort), .frameAvail(frameAvail),
    .rdValid(rdValid), .rdData(rdData), .rdAttr(rdAttr)
  );

  rx_frame_dispatch #(.DATA_W(64)) dut64_i (
    .clk(clk), .rstN(rstN), .loadValid(wLoadValid), .loadPort(wLoadPort),
    .loadData(wLoadData), .loadLast(wLoadLast), .loadBytes(wLoadBytes),
    .rdEnN(wRdEnN), .passReq(wPass), .skipReq(1'b0), .tailMode(wTail),
    .busDriven(wBusDriven), .rdPort(wRdPort), .frameAvail(wFrameAvail),
    .rdValid(wRdValid), .rdData(wRdData), .rdAttr(wRdAttr)
  );

  // {skip, pass, expected port, expected frameAvail}
  localparam logic [5:0] WALK [10] = '{
    {1'b1, 1'b0, 3'd1, 1'b0},
    {1'b1, 1'b0, 3'd2, 1'b1},
    {1'b1, 1'b1, 3'd3, 1'b0},
    {1'b1, 1'b0, 3'd4, 1'b0},
    {1'b1, 1'b0, 3'd5, 1'b1},
    {1'b1, 1'b0, 3'd6, 1'b0},
    {1'b1, 1'b0, 3'd7, 1'b0},
    {1'b1, 1'b0, 3'd0, 1'b0},
    {1'b1, 1'b0, 3'd1, 1'b0},
    {1'b1, 1'b0, 3'd2, 1'b1}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadFrame(logic [2:0] port, int nWords, logic [2:0] lastBytes,
                           logic [31:0] base, logic withLast);
    for (int i = 0; i < nWords; i++) begin
      loadValid = 1;
      loadPort  = port;
      loadData  = base + 32'(i);
      loadLast  = withLast && (i == nWords - 1);
      loadBytes = (i == nWords - 1) ? lastBytes : 3'd4;
      step();
    end
    loadValid = 0;
    loadLast  = 0;
  endtask

  task automatic loadWide(int nWords, logic [3:0] lastBytes, logic [63:0] base);
    for (int i = 0; i < nWords; i++) begin
      wLoadValid = 1;
      wLoadPort  = 3'd0;
      wLoadData  = base + 64'(i);
      wLoadLast  = (i == nWords - 1);
      wLoadBytes = (i == nWords - 1) ? lastBytes : 4'd8;
      step();
    end
    wLoadValid = 0;
    wLoadLast  = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 busDriven", busDriven, 0);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 rdPort", rdPort, 0);
    chk("R1 frameAvail", frameAvail, 0);
    rstN = 1;
    step();

    loadFrame(3'd2, 3, 3'd3, 32'h2000, 1'b1);
    loadFrame(3'd5, 1, 3'd2, 32'h5000, 1'b1);
    loadFrame(3'd3, 2, 3'd4, 32'h3000, 1'b0);

    // R2: released bus shows nothing, skip while disabled ignored
    chk("R2 busDriven off", busDriven, 0);
    chk("R2 rdData zero", rdData, 0);
    skipReq = 1;
    step();
    skipReq = 0;
    rdEnN = 0;
    step();
    chk("R2 skip ignored while disabled", rdPort, 0);
    chk("R1 busDriven after enable", busDriven, 1);

    // R3/R4: table walk over the ports
    foreach (WALK[i]) begin
      skipReq = WALK[i][5];
      passReq = WALK[i][4];
      step();
      skipReq = 0;
      passReq = 0;
      chk("R4 rdPort walk", rdPort, WALK[i][3:1]);
      chk("R3 frameAvail walk", frameAvail, WALK[i][0]);
      chk("R4 no transfer on skip", rdValid, 0);
    end

    // R5/R6/R9/R10: three-word frame on port 2
    passReq = 1;
    step();
    passReq = 0;
    chk("R5 no word on pass edge", rdValid, 0);
    step();
    chk("R5 first word data", rdData, 32'h2000);
    chk("R6 start code", rdAttr, 4'b0001);
    rdEnN = 1;
    step();
    chk("R9 paused no word", rdValid, 0);
    chk("R2 busDriven paused", busDriven, 0);
    rdEnN = 0;
    skipReq = 1;
    step();
    skipReq = 0;
    chk("R9 resumed word", rdData, 32'h2001);
    chk("R6 middle code", rdAttr, 4'b0000);
    chk("R10 port held", rdPort, 3'd2);
    step();
    chk("R5 last word data", rdData, 32'h2002);
    chk("R6 end code 3 bytes", rdAttr, 4'b1011);
    chk("R8 frame removed after end", frameAvail, 0);

    // R5: pass with no frame ignored
    passReq = 1;
    step();
    passReq = 0;
    step();
    chk("R5 pass without frame", rdValid, 0);

    // R7/R8: tail mode on port 5 with a second frame queued
    loadFrame(3'd5, 2, 3'd4, 32'h5100, 1'b1);
    repeat (3) begin
      skipReq = 1;
      step();
    end
    skipReq = 0;
    chk("R4 reached port 5", rdPort, 3'd5);
    tailMode = 1;
    passReq = 1;
    step();
    passReq = 0;
    step();
    chk("R6 single word end code", rdAttr, 4'b1010);
    chk("R5 single word data", rdData, 32'h5000);
    step();
    chk("R7 length code", rdAttr, 4'b0010);
    chk("R7 length value", rdData, 32'd2);
    chk("R8 frame kept before status", frameAvail, 1);
    step();
    chk("R7 status code", rdAttr, 4'b0011);
    chk("R7 status value", rdData, 32'h0005_0001);
    chk("R3 second frame still ready", frameAvail, 1);
    tailMode = 0;
    passReq = 1;
    step();
    passReq = 0;
    step();
    chk("R5 second frame order", rdData, 32'h5100);
    step();
    chk("R6 full 32-bit end code", rdAttr, 4'b1100);
    chk("R8 port 5 drained", frameAvail, 0);

    // R3: completing the partial frame on port 3
    loadFrame(3'd3, 1, 3'd1, 32'h3002, 1'b1);
    repeat (6) begin
      skipReq = 1;
      step();
    end
    skipReq = 0;
    chk("R4 wrapped to port 3", rdPort, 3'd3);
    chk("R3 completed frame ready", frameAvail, 1);

    // R11: 64-bit width
    loadWide(2, 4'd7, 64'h1111_0000_0000_0000);
    wRdEnN = 0;
    wPass = 1;
    step();
    wPass = 0;
    chk("R11 wide avail", wRdPort, 3'd0);
    step();
    chk("R11 wide start code", wRdAttr, 4'b0001);
    step();
    chk("R11 wide 7-byte end", wRdAttr, 4'b1111);
    chk("R11 wide end data", wRdData, 64'h1111_0000_0000_0001);
    loadWide(1, 4'd8, 64'h2222_0000_0000_0000);
    wTail = 1;
    wPass = 1;
    step();
    wPass = 0;
    step();
    chk("R11 wide full end", wRdAttr, 4'b1000);
    step();
    chk("R11 wide length", wRdData, 64'd8);
    step();
    chk("R11 wide status", wRdData, 64'h0000_0000_0000_0001);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule